// File: doc/BRIEF.md
# Saturating Hit and Miss Monitors

This block keeps two performance counters for a cache. One counts lookups that hit and the other counts lookups that miss. The lookup stage sends it one-cycle hit and miss pulses. The block does not create those events and holds no cache storage. It only counts them and shows the totals to software.

The hit counter is `HIT_W` bits wide (32 by default) and the miss counter is `MISS_W` bits wide (16 by default). Neither counter wraps. Each one stops at its all-ones value and stays there. A four-bit control field gives each counter its own enable bit and its own clear bit. Software writes the whole field at once, so one write can start, stop or clear either counter or both. To clear a counter, software sets its clear bit and then writes it back to zero. While the clear bit is set, the counter stays at zero.

All registers are reached through a small register port: an address, a write strobe, four bits of write data, and read data that follows the address in the same cycle.

Top module: `hitmiss_monitor`

## Requirements
- R1: After reset the control field, the hit count and the miss count all read as zero.
- R2: While control bit 0 (hit enable) is 1 and control bit 2 is 0, each clock edge that samples `hit_evt` high adds one to the hit count.
- R3: While control bit 1 (miss enable) is 1 and control bit 3 is 0, each clock edge that samples `miss_evt` high adds one to the miss count.
- R4: The hit count stops at 2^HIT_W-1 and stays there when further hit pulses arrive.
- R5: The miss count stops at 2^MISS_W-1 and stays there when further miss pulses arrive.
- R6: A counter whose enable bit is 0 keeps its current value and ignores its events.
- R7: While control bit 2 (hit clear) or bit 3 (miss clear) is 1, that counter is forced to zero and ignores its events. Once the bit is written back to 0, the counter counts up from zero again.
- R8: A write to address 0 loads all four control bits at once, so one write can change the enable and clear bits of both counters.
- R9: A hit pulse and a miss pulse in the same cycle each change only their own counter.
- R10: Writes to address 1 or 2 change neither count nor the control field.
- R11: The read map is:
  - address 0: the control field, zero-extended;
  - address 1: the hit count, zero-extended;
  - address 2: the miss count, zero-extended;
  - address 3: zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| hit_evt | input | 1 | One-cycle hit pulse from the lookup stage |
| miss_evt | input | 1 | One-cycle miss pulse from the lookup stage |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register address used for both reads and writes |
| reg_wdata | input | 4 | Write data for the control field |
| reg_rdata | output | DATA_W | Read data for the register selected by `reg_addr` |

## Verification
A pulse that is high at a rising edge shows up in the count at that same edge. Read data depends only on the address, so the new count can be read in the second half of that cycle. A control write also takes effect at its own edge. Event pulses use the control value from before that edge, so they see the new settings only from the next edge onward. The bench changes its inputs just after each falling edge and reads every register in the half cycle that follows, before the next rising edge. The bench model therefore updates the counts with the old control bits and then applies any write.

// File: rtl/hmmon_pkg.sv
package hmmon_pkg;

  // Width of the writable control field
  localparam int CTRL_W = 4;

  // Register addresses; each clear bit sits two places above its enable bit
  localparam int ADDR_CTRL = 0;
  localparam int ADDR_HIT  = 1;
  localparam int ADDR_MISS = 2;

  typedef struct packed {
    logic miss_clr;  // bit 3
    logic hit_clr;   // bit 2
    logic miss_on;   // bit 1
    logic hit_on;    // bit 0
  } mon_ctrl_t;

endpackage

// File: rtl/hmmon_ctrl.sv
module hmmon_ctrl
  import hmmon_pkg::*;
#(
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [CTRL_W-1:0] wdata,
  output mon_ctrl_t         ctrl
);

  logic      ctrl_we;
  mon_ctrl_t ctrl_d;

  // Next state: load the whole field when the control address is written
  always_comb begin
    ctrl_we = wr_en && (addr == ADDR_W'(ADDR_CTRL));
    ctrl_d  = ctrl;
    if (ctrl_we) begin
      ctrl_d = mon_ctrl_t'(wdata);
    end
  end

  // Register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl <= '0;
    end else begin
      ctrl <= ctrl_d;
    end
  end

  a_r8_ctrl_load: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == ADDR_W'(ADDR_CTRL)) |=> (ctrl == mon_ctrl_t'($past(wdata))));

  a_r10_ctrl_kept: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && addr == ADDR_W'(ADDR_CTRL)) |=> $stable(ctrl));

endmodule

// File: rtl/hmmon_satcnt.sv
module hmmon_satcnt #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] count
);

  localparam logic [W-1:0] CNT_MAX = '1;

  logic         at_max;
  logic         cnt_en;
  logic [W-1:0] count_d;

  // Next state: clear has priority; an increment is dropped once at the top
  always_comb begin
    at_max  = (count == CNT_MAX);
    cnt_en  = clr || (inc && !at_max);
    count_d = count;
    if (clr) begin
      count_d = '0;
    end else if (inc && !at_max) begin
      count_d = count + 1'b1;
    end
  end

  // Register with its clock enable written out
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count <= '0;
    end else if (cnt_en) begin
      count <= count_d;
    end
  end

  // Covers R4 and R5, depending on the instance
  a_r4_sat_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (count == CNT_MAX && !clr) |=> (count == CNT_MAX));

  a_r2_step: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !clr && count != CNT_MAX) |=> (count == W'($past(count) + 1'b1)));

  a_r6_freeze: assert property (@(posedge clk) disable iff (!rst_n)
    (!inc && !clr) |=> $stable(count));

  a_r7_clr_zero: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (count == '0));

endmodule

// File: rtl/hmmon_rdmux.sv
module hmmon_rdmux
  import hmmon_pkg::*;
#(
  parameter int ADDR_W = 2,
  parameter int DATA_W = 32,
  parameter int HIT_W  = 32,
  parameter int MISS_W = 16
) (
  input  logic [ADDR_W-1:0] addr,
  input  mon_ctrl_t         ctrl,
  input  logic [HIT_W-1:0]  hit_cnt,
  input  logic [MISS_W-1:0] miss_cnt,
  output logic [DATA_W-1:0] rdata
);

  // Every register is zero-extended to the bus width; unused addresses read zero
  always_comb begin
    rdata = '0;
    case (addr)
      ADDR_W'(ADDR_CTRL): rdata = DATA_W'(ctrl);
      ADDR_W'(ADDR_HIT):  rdata = DATA_W'(hit_cnt);
      ADDR_W'(ADDR_MISS): rdata = DATA_W'(miss_cnt);
      default:            rdata = '0;
    endcase
  end

endmodule

// File: rtl/hitmiss_monitor.sv
module hitmiss_monitor
  import hmmon_pkg::*;
#(
  parameter int HIT_W  = 32,
  parameter int MISS_W = 16,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hit_evt,
  input  logic              miss_evt,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [CTRL_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata
);

  mon_ctrl_t         ctrl;
  logic [HIT_W-1:0]  hit_cnt;
  logic [MISS_W-1:0] miss_cnt;
  logic              hit_inc;
  logic              miss_inc;

  hmmon_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_en (reg_wr),
    .addr  (reg_addr),
    .wdata (reg_wdata),
    .ctrl  (ctrl)
  );

  // Each event is gated only by its own enable bit
  assign hit_inc  = hit_evt  && ctrl.hit_on;
  assign miss_inc = miss_evt && ctrl.miss_on;

  hmmon_satcnt #(.W(HIT_W)) u_hit_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (ctrl.hit_clr),
    .inc   (hit_inc),
    .count (hit_cnt)
  );

  hmmon_satcnt #(.W(MISS_W)) u_miss_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (ctrl.miss_clr),
    .inc   (miss_inc),
    .count (miss_cnt)
  );

  hmmon_rdmux #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .HIT_W  (HIT_W),
    .MISS_W (MISS_W)
  ) u_rdmux (
    .addr     (reg_addr),
    .ctrl     (ctrl),
    .hit_cnt  (hit_cnt),
    .miss_cnt (miss_cnt),
    .rdata    (reg_rdata)
  );

  a_r9_miss_untouched_by_hit: assert property (@(posedge clk) disable iff (!rst_n)
    (!miss_evt && !ctrl.miss_clr) |=> $stable(miss_cnt));

  a_r9_hit_untouched_by_miss: assert property (@(posedge clk) disable iff (!rst_n)
    (!hit_evt && !ctrl.hit_clr) |=> $stable(hit_cnt));

endmodule

// File: tb/sim_hitmiss_monitor.sv
`timescale 1ns/1ps
module sim_hitmiss_monitor;

  localparam int HW = 6;
  localparam int MW = 4;
  localparam int HMAX = (1 << HW) - 1;
  localparam int MMAX = (1 << MW) - 1;

  logic        clk;
  logic        rst_n;
  logic        hit_evt;
  logic        miss_evt;
  logic        reg_wr;
  logic [1:0]  reg_addr;
  logic [3:0]  reg_wdata;
  logic [31:0] reg_rdata;

  int checks;
  int fails;
  int hm;
  int mm;
  logic [3:0] cm;
  bit done;

  hitmiss_monitor #(.HIT_W(HW), .MISS_W(MW), .DATA_W(32), .ADDR_W(2)) u0 (
    .clk       (clk),
    .rst_n     (rst_n),
    .hit_evt   (hit_evt),
    .miss_evt  (miss_evt),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // One clock cycle of stimulus; the model uses the control bits from before the edge
  task automatic cyc(input bit h, input bit m, input bit wr, input logic [1:0] a, input logic [3:0] wd);
    hit_evt = h; miss_evt = m; reg_wr = wr; reg_addr = a; reg_wdata = wd;
    @(posedge clk);
    if (cm[2]) hm = 0; else if (cm[0] && h && hm < HMAX) hm++;
    if (cm[3]) mm = 0; else if (cm[1] && m && mm < MMAX) mm++;
    if (wr && a == 2'd0) cm = wd;
    @(negedge clk);
    hit_evt = 0; miss_evt = 0; reg_wr = 0;
  endtask

  // Read all four addresses in the low half of the clock
  task automatic check_all(input string hit_tag, input string miss_tag);
    reg_addr = 2'd0; #0.4; chk("R8 R11 ctrl", reg_rdata, {28'd0, cm});
    reg_addr = 2'd1; #0.4; chk(hit_tag, reg_rdata, 32'(hm));
    reg_addr = 2'd2; #0.4; chk(miss_tag, reg_rdata, 32'(mm));
    reg_addr = 2'd3; #0.4; chk("R11 spare", reg_rdata, 32'd0);
  endtask

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    checks = 0; fails = 0; hm = 0; mm = 0; cm = 4'd0; done = 0;
    rst_n = 0; hit_evt = 0; miss_evt = 0; reg_wr = 0; reg_addr = 0; reg_wdata = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check_all("R1 hit", "R1 miss");

    // Every control value against every pulse pattern (R2 R3 R6 R7 R9)
    for (int c = 0; c < 16; c++) begin
      cyc(0, 0, 1, 2'd0, 4'(c));
      check_all("R8 ctrl write hit", "R8 ctrl write miss");
      for (int p = 0; p < 8; p++) begin
        cyc(p[0], p[1], 0, 2'd0, 4'd0);
        check_all("R2 R6 R7 R9 hit", "R3 R6 R7 R9 miss");
      end
    end

    // Saturation of both counters
    cyc(0, 0, 1, 2'd0, 4'b1100);
    cyc(0, 0, 1, 2'd0, 4'b0011);
    for (int i = 0; i < 80; i++) begin
      cyc(1, (i % 3) != 2, 0, 2'd0, 4'd0);
      check_all("R4 hit sat", "R5 miss sat");
    end

    // Disabling freezes the count
    cyc(0, 0, 1, 2'd0, 4'b1100);
    cyc(0, 0, 1, 2'd0, 4'b0011);
    for (int i = 0; i < 5; i++) cyc(1, 1, 0, 2'd0, 4'd0);
    cyc(0, 0, 1, 2'd0, 4'b0010);
    for (int i = 0; i < 5; i++) cyc(1, 1, 0, 2'd0, 4'd0);
    check_all("R6 hit frozen", "R6 miss still on");

    // Count registers ignore writes
    cyc(0, 0, 1, 2'd1, 4'hF);
    cyc(0, 0, 1, 2'd2, 4'hF);
    check_all("R10 hit ro", "R10 miss ro");

    // Clear held while the bit is set, then counting resumes from zero
    cyc(0, 0, 1, 2'd0, 4'b1111);
    for (int i = 0; i < 3; i++) cyc(1, 1, 0, 2'd0, 4'd0);
    check_all("R7 hit held", "R7 miss held");
    cyc(0, 0, 1, 2'd0, 4'b0011);
    for (int i = 0; i < 4; i++) cyc(1, 0, 0, 2'd0, 4'd0);
    check_all("R7 hit resume", "R9 miss untouched");

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule